// File: doc/BRIEF.md
# SD card SPI command engine

This block sends one command to a memory card in SPI mode and brings back the card's answer. It works over a byte-transfer handshake to an SPI master: the engine asks for one byte at a time, hands over the byte to shift out, and waits for a strobe that carries the byte shifted in. The bit-level shifter is not part of the block. When a command is accepted, chip select goes low and the six-byte frame goes out. This frame holds a start marker merged with the command index, the argument in big-endian order and a fixed check byte. The engine then clocks out filler bytes until the card replies.

The status byte is the first received byte whose top bit is clear. For the two commands that return a 32-bit register (indices 8 and 58), four more bytes are read while the card stays selected. Chip select is then raised, and one more filler byte is clocked so the card can release its output. If no status byte comes within the polling limit, the engine raises a timeout flag and reports 0xFF. A keep-selected mode finishes as soon as the status byte arrives. In that mode chip select stays low, so a register read or data phase can follow.

Top module: `sd_cmd_engine`

## Requirements
- R1: Frame byte 0 equals 0x40 OR the 6-bit command index; bytes 1 to 4 carry the 32-bit argument, bits 31:24 first and bits 7:0 last; all are sent with cs_n low.
- R2: Frame byte 5 is 0x87 when the command index is 8 and 0x95 for every other index.
- R3: After the frame the engine sends 0xFF bytes with cs_n low; the first received byte with bit 7 equal to 0 is reported on r1_status, and received bytes with bit 7 set (any value) keep the polling going.
- R4: At most POLL_LIMIT (5000) filler bytes are polled; a status byte on poll number POLL_LIMIT is still accepted; if none arrives, timed_out is 1, r1_status is 0xFF and reg_word is 0.
- R5: Outside keep-selected completion, the last transfer of a command is one 0xFF byte sent with cs_n high, and cmd_done pulses in the cycle after that byte completes.
- R6: For command index 8 or 58 (not in keep-selected mode), four 0xFF bytes follow the status byte with cs_n low and the received bytes are placed in reg_word most significant first; every other command leaves reg_word at 0.
- R7: With keep_sel set, a received status byte ends the command at once: no register bytes, no trailing byte, and cs_n stays low after cmd_done.
- R8: start is ignored while busy is high; command index, argument and keep_sel are taken at the accepting edge and later changes on those inputs do not alter the frame.
- R9: Only one byte request is outstanding at a time; busy is high from the cycle after an accepted start through the last transfer, is low in the cmd_done cycle, and a start in that cycle is accepted.
- R10: After reset cs_n is 1 and busy, cmd_done and xfer_req are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to send a command (taken when busy is low) |
| cmd_index | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| keep_sel | input | 1 | Keep-selected mode: finish right after the status byte |
| busy | output | 1 | A command is in progress |
| cmd_done | output | 1 | One-cycle completion strobe |
| r1_status | output | 8 | Status byte received (0xFF on timeout) |
| reg_word | output | 32 | Four trailing bytes, most significant first |
| timed_out | output | 1 | No status byte within the polling limit |
| cs_n | output | 1 | Card chip select, active low |
| xfer_req | output | 1 | One-cycle request for a byte transfer |
| xfer_tx | output | 8 | Byte to shift out, valid while a transfer is pending |
| xfer_done | input | 1 | Byte transfer finished strobe |
| xfer_rx | input | 8 | Byte shifted in, valid with xfer_done |

## Verification
Completion of one command and acceptance of the next can share a cycle, because busy already reads low while cmd_done is high. The bench raises start in exactly the cycle in which it sees cmd_done. It then requires that the finished command's results are intact. It also requires that the new frame follows with the new index and argument, and that the clock-by-clock reference for busy and cmd_done still matches. A second pairing, a start request arriving mid-command, is provoked with a different index on the inputs and judged by the unchanged frame and by the absence of any extra transfer afterwards.

// File: rtl/sdce_pkg.sv
package sdce_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FRAME,
    ST_POLL,
    ST_EXT,
    ST_TAIL
  } sdce_state_e;

  localparam logic [7:0] SDCE_FILL = 8'hFF;
  localparam int unsigned SDCE_FRAME_LEN = 6;

  // Fixed check byte; only the interface-condition command needs a different one
  function automatic logic [7:0] sdce_check_byte(input logic [5:0] idx);
    return (idx == 6'd8) ? 8'h87 : 8'h95;
  endfunction

  // Byte at position pos of the six-byte command frame
  function automatic logic [7:0] sdce_frame_byte(input logic [5:0] idx,
                                                 input logic [31:0] arg,
                                                 input logic [2:0] pos);
    logic [7:0] b;
    case (pos)
      3'd0:    b = {2'b01, idx};
      3'd1:    b = arg[31:24];
      3'd2:    b = arg[23:16];
      3'd3:    b = arg[15:8];
      3'd4:    b = arg[7:0];
      default: b = sdce_check_byte(idx);
    endcase
    return b;
  endfunction

  // Commands whose reply carries a 32-bit register after the status byte
  function automatic logic sdce_wants_reg(input logic [5:0] idx);
    return (idx == 6'd8) || (idx == 6'd58);
  endfunction

  function automatic logic sdce_is_status(input logic [7:0] b);
    return !b[7];
  endfunction

endpackage

// File: rtl/sdce_poll_ctr.sv
module sdce_poll_ctr #(
  parameter int unsigned LIMIT = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic last
);
  localparam int unsigned CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= cnt + 1'b1;
  end

  // The poll now completing is number LIMIT
  assign last = (cnt == CW'(LIMIT - 1));

  a_r4_poll_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(LIMIT));

endmodule

// File: rtl/sdce_word_asm.sv
module sdce_word_asm #(
  parameter int unsigned NBYTES = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic                  shift,
  input  logic [7:0]            byte_in,
  output logic [NBYTES*8-1:0]   word
);
  localparam int unsigned WW = NBYTES * 8;

  always_ff @(posedge clk) begin
    if (!rst_n)     word <= '0;
    else if (clr)   word <= '0;
    else if (shift) word <= {word[WW-9:0], byte_in};
  end

endmodule

// File: rtl/sd_cmd_engine.sv
module sd_cmd_engine
  import sdce_pkg::*;
#(
  parameter int unsigned POLL_LIMIT = 5000,
  parameter int unsigned REG_BYTES  = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [5:0]             cmd_index,
  input  logic [31:0]            cmd_arg,
  input  logic                   keep_sel,
  output logic                   busy,
  output logic                   cmd_done,
  output logic [7:0]             r1_status,
  output logic [REG_BYTES*8-1:0] reg_word,
  output logic                   timed_out,
  output logic                   cs_n,
  output logic                   xfer_req,
  output logic [7:0]             xfer_tx,
  input  logic                   xfer_done,
  input  logic [7:0]             xfer_rx
);
  localparam logic [2:0] FRAME_LAST = 3'(SDCE_FRAME_LEN - 1);
  localparam logic [2:0] REG_LAST   = 3'(REG_BYTES - 1);

  sdce_state_e state;
  logic [2:0]  bcnt;
  logic        pend;
  logic [5:0]  idx_q;
  logic [31:0] arg_q;
  logic        hold_q;
  logic        reg_q;

  // Named internal events
  logic ev_accept;
  logic ev_byte_done;
  logic ev_status;
  logic ev_expire;
  logic poll_last;

  assign busy         = (state != ST_IDLE);
  assign ev_accept    = (state == ST_IDLE) && start;
  assign ev_byte_done = busy && pend && xfer_done;
  assign ev_status    = ev_byte_done && (state == ST_POLL) && sdce_is_status(xfer_rx);
  assign ev_expire    = ev_byte_done && (state == ST_POLL) && !sdce_is_status(xfer_rx) && poll_last;

  always_comb begin
    xfer_tx = (state == ST_FRAME) ? sdce_frame_byte(idx_q, arg_q, bcnt) : SDCE_FILL;
  end

  sdce_poll_ctr #(.LIMIT(POLL_LIMIT)) u_poll (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (ev_accept),
    .inc   (ev_byte_done && (state == ST_POLL)),
    .last  (poll_last)
  );

  sdce_word_asm #(.NBYTES(REG_BYTES)) u_word (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (ev_accept),
    .shift   (ev_byte_done && (state == ST_EXT)),
    .byte_in (xfer_rx),
    .word    (reg_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      bcnt      <= '0;
      pend      <= 1'b0;
      xfer_req  <= 1'b0;
      cmd_done  <= 1'b0;
      cs_n      <= 1'b1;
      r1_status <= 8'h00;
      timed_out <= 1'b0;
      idx_q     <= '0;
      arg_q     <= '0;
      hold_q    <= 1'b0;
      reg_q     <= 1'b0;
    end else begin
      xfer_req <= 1'b0;
      cmd_done <= 1'b0;
      if (state == ST_IDLE) begin
        if (ev_accept) begin
          idx_q  <= cmd_index;
          arg_q  <= cmd_arg;
          hold_q <= keep_sel;
          reg_q  <= sdce_wants_reg(cmd_index);
          cs_n   <= 1'b0;
          bcnt   <= '0;
          pend   <= 1'b0;
          state  <= ST_FRAME;
        end
      end else if (!pend) begin
        xfer_req <= 1'b1;
        pend     <= 1'b1;
      end else if (ev_byte_done) begin
        pend <= 1'b0;
        case (state)
          ST_FRAME: begin
            if (bcnt == FRAME_LAST) begin
              bcnt  <= '0;
              state <= ST_POLL;
            end else begin
              bcnt <= bcnt + 3'd1;
            end
          end
          ST_POLL: begin
            if (ev_status) begin
              r1_status <= xfer_rx;
              timed_out <= 1'b0;
              if (hold_q) begin
                cmd_done <= 1'b1;
                state    <= ST_IDLE;
              end else if (reg_q) begin
                bcnt  <= '0;
                state <= ST_EXT;
              end else begin
                cs_n  <= 1'b1;
                state <= ST_TAIL;
              end
            end else if (ev_expire) begin
              r1_status <= 8'hFF;
              timed_out <= 1'b1;
              cs_n      <= 1'b1;
              state     <= ST_TAIL;
            end
          end
          ST_EXT: begin
            if (bcnt == REG_LAST) begin
              cs_n  <= 1'b1;
              state <= ST_TAIL;
            end else begin
              bcnt <= bcnt + 3'd1;
            end
          end
          default: begin
            cmd_done <= 1'b1;
            state    <= ST_IDLE;
          end
        endcase
      end
    end
  end

  // R9: requests only inside a command, and the done strobe lasts one cycle
  a_r9_req_in_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req |-> busy);
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |=> !cmd_done);
  a_r9_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |-> !busy);
  // R5: the trailing filler goes out deselected
  a_r5_tail_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TAIL && xfer_req) |-> cs_n);
  // R6: register bytes are read with the card selected
  a_r6_reg_selected: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_EXT && xfer_req) |-> !cs_n);
  // R7: keep-selected completion leaves the card selected
  a_r7_hold_selected: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_done && hold_q && !timed_out) |-> !cs_n);
  // R3: a reported status byte always has its top bit clear
  a_r3_status_form: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_done && !timed_out) |-> !r1_status[7]);
  // R8: latched command stays fixed while the command runs
  a_r8_latched_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(idx_q) && $stable(arg_q) && $stable(hold_q)));

endmodule

// File: tb/sd_cmd_engine_tb.sv
`timescale 1ns/1ps
module sd_cmd_engine_tb;

  localparam int LIMIT = 5000;
  localparam int LAT   = 2;
  localparam int WD    = 190000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [5:0]  cmd_index = '0;
  logic [31:0] cmd_arg = '0;
  logic        keep_sel = 1'b0;
  logic        busy, cmd_done, timed_out, cs_n, xfer_req;
  logic [7:0]  r1_status, xfer_tx;
  logic [31:0] reg_word;
  logic        xfer_done = 1'b0;
  logic [7:0]  xfer_rx = 8'hFF;

  always #2.5 clk = ~clk;

  sd_cmd_engine u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_index(cmd_index),
    .cmd_arg(cmd_arg), .keep_sel(keep_sel), .busy(busy), .cmd_done(cmd_done),
    .r1_status(r1_status), .reg_word(reg_word), .timed_out(timed_out),
    .cs_n(cs_n), .xfer_req(xfer_req), .xfer_tx(xfer_tx),
    .xfer_done(xfer_done), .xfer_rx(xfer_rx)
  );

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  bit finished = 0;

  // Card script
  int         s_lead = 0;
  logic [7:0] s_lead_byte = 8'hFF;
  logic [7:0] s_r1 = 8'h00;
  logic [31:0] s_ext = '0;
  int         nx_total = 0;

  // Logged transfers
  logic [7:0] log_tx[$];
  logic       log_cs[$];

  // Reference model state
  int  lat_cnt = 0;
  int  bidx = 0;
  bit  m_busy = 0;
  bit  m_done = 0;
  int  m_left = 0;
  int  proto_err = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  function automatic logic [7:0] rx_for(input int n);
    int k;
    if (n < 6) return 8'hFF;
    if (n < 6 + s_lead) return s_lead_byte;
    if (n == 6 + s_lead) return s_r1;
    k = n - 7 - s_lead;
    if (k < 4) return 8'(s_ext >> (8 * (3 - k)));
    return 8'hFF;
  endfunction

  function automatic bit found_for(input int lead);
    return lead < LIMIT;
  endfunction

  function automatic int total_for(input logic [5:0] idx, input bit hold, input int lead);
    bit f = found_for(lead);
    int t = 6 + (f ? lead + 1 : LIMIT);
    if (f && !hold && (idx == 8 || idx == 58)) t += 4;
    if (!(f && hold)) t += 1;
    return t;
  endfunction

  // SPI byte slave and cycle reference for busy / cmd_done
  always @(posedge clk) begin
    cyc <= cyc + 1;
    xfer_done <= 1'b0;
    m_done <= 1'b0;
    if (!rst_n) begin
      lat_cnt <= 0;
      m_busy <= 0;
      m_left <= 0;
    end else begin
      if (xfer_done) begin
        m_left <= m_left - 1;
        if (m_left == 1) begin
          m_busy <= 0;
          m_done <= 1;
        end
      end
      if (lat_cnt > 0) begin
        lat_cnt <= lat_cnt - 1;
        if (lat_cnt == 1) begin
          xfer_done <= 1'b1;
          xfer_rx <= rx_for(bidx);
          bidx <= bidx + 1;
        end
      end
      if (xfer_req) begin
        if (lat_cnt != 0 || xfer_done || !m_busy) proto_err <= proto_err + 1;
        log_tx.push_back(xfer_tx);
        log_cs.push_back(cs_n);
        lat_cnt <= LAT;
      end
      if (start && !m_busy) begin
        m_busy <= 1;
        m_left <= nx_total;
        bidx <= 0;
      end
    end
  end

  // R9: every clock, busy and cmd_done follow the reference
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(busy == m_busy, "R9", "busy vs reference", 64'(busy), 64'(m_busy));
      chk(cmd_done == m_done, "R9", "cmd_done vs reference", 64'(cmd_done), 64'(m_done));
    end
  end

  always @(posedge clk) begin
    if (cyc >= WD && !finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, WD);
      report();
    end
  end

  task automatic launch(input logic [5:0] idx, input logic [31:0] arg, input bit hold,
                        input int lead, input logic [7:0] lbyte, input logic [7:0] r1b,
                        input logic [31:0] ext);
    s_lead = lead; s_lead_byte = lbyte; s_r1 = r1b; s_ext = ext;
    nx_total = total_for(idx, hold, lead);
    log_tx.delete();
    log_cs.delete();
    cmd_index = idx; cmd_arg = arg; keep_sel = hold;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    while (!cmd_done) @(negedge clk);
  endtask

  // Called in the cmd_done cycle
  task automatic judge(input logic [5:0] idx, input logic [31:0] arg, input bit hold,
                       input int lead, input logic [7:0] r1b, input logic [31:0] ext);
    bit f = found_for(lead);
    int npoll = f ? lead + 1 : LIMIT;
    bit ext_on = f && !hold && (idx == 8 || idx == 58);
    bit tail = !(f && hold);
    int tot = total_for(idx, hold, lead);
    logic [7:0] fr[6];
    int bad_frame = 0, bad_poll = 0, bad_ext = 0, bad_tail = 0;
    fr[0] = 8'h40 + 8'(idx);
    for (int i = 0; i < 4; i++) fr[i+1] = 8'(arg >> (24 - 8 * i));
    fr[5] = (idx == 6'd8) ? 8'h87 : 8'h95;
    chk(log_tx.size() == tot, "R3", "transfer count", 64'(log_tx.size()), 64'(tot));
    if (log_tx.size() == tot) begin
      for (int i = 0; i < 5; i++) if (log_tx[i] !== fr[i] || log_cs[i] !== 1'b0) bad_frame++;
      chk(bad_frame == 0, "R1", "frame bytes 0..4", 64'(log_tx[0]), 64'(fr[0]));
      chk(log_tx[5] === fr[5] && log_cs[5] === 1'b0, "R2", "check byte", 64'(log_tx[5]), 64'(fr[5]));
      for (int i = 6; i < 6 + npoll; i++) if (log_tx[i] !== 8'hFF || log_cs[i] !== 1'b0) bad_poll++;
      chk(bad_poll == 0, "R3", "poll fillers selected", 64'(bad_poll), 64'd0);
      if (ext_on) begin
        for (int i = 6 + npoll; i < 10 + npoll; i++) if (log_tx[i] !== 8'hFF || log_cs[i] !== 1'b0) bad_ext++;
        chk(bad_ext == 0, "R6", "register bytes selected", 64'(bad_ext), 64'd0);
      end
      if (tail) begin
        if (log_tx[tot-1] !== 8'hFF || log_cs[tot-1] !== 1'b1) bad_tail++;
        chk(bad_tail == 0, "R5", "trailing byte deselected", 64'(log_cs[tot-1]), 64'd1);
      end
    end
    chk(r1_status === (f ? r1b : 8'hFF), f ? "R3" : "R4", "status byte", 64'(r1_status), 64'(f ? r1b : 8'hFF));
    chk(timed_out === !f, "R4", "timeout flag", 64'(timed_out), 64'(!f));
    chk(reg_word === (ext_on ? ext : 32'h0), "R6", "register word", 64'(reg_word), 64'(ext_on ? ext : 32'h0));
    chk(cs_n === !(f && hold), hold ? "R7" : "R5", "cs_n after done", 64'(cs_n), 64'(!(f && hold)));
  endtask

  task automatic run(input logic [5:0] idx, input logic [31:0] arg, input bit hold,
                     input int lead, input logic [7:0] lbyte, input logic [7:0] r1b,
                     input logic [31:0] ext);
    launch(idx, arg, hold, lead, lbyte, r1b, ext);
    wait_done();
    judge(idx, arg, hold, lead, r1b, ext);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(cs_n === 1'b1, "R10", "cs_n in reset", 64'(cs_n), 64'd1);
    chk(busy === 1'b0 && cmd_done === 1'b0 && xfer_req === 1'b0, "R10", "busy/done/req in reset",
        64'({busy, cmd_done, xfer_req}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n === 1'b1 && busy === 1'b0, "R10", "idle after reset", 64'({cs_n, busy}), 64'b10);

    // R1 R2 R3 R5: plain command with two idle bytes before status
    run(6'd0, 32'h0, 1'b0, 2, 8'hFF, 8'h01, 32'h0);
    // R2 R6: interface-condition command with register word
    run(6'd8, 32'h0000_01AA, 1'b0, 0, 8'hFF, 8'h01, 32'h0000_01AA);
    // R3 R6: odd busy-looking bytes with bit 7 set before status
    run(6'd58, 32'h0, 1'b0, 3, 8'hC5, 8'h00, 32'hC0FF_8000);
    // R1 R6: argument ordering, no register word for other commands
    run(6'd17, 32'h1234_5678, 1'b0, 1, 8'h80, 8'h04, 32'hDEAD_BEEF);
    // R7: keep-selected read
    run(6'd9, 32'h0, 1'b1, 1, 8'hFF, 8'h00, 32'h0);
    // R7: keep-selected with a register-returning command skips the word
    run(6'd58, 32'h0, 1'b1, 0, 8'hFF, 8'h00, 32'h1111_2222);
    // R4: status on the last allowed poll is accepted
    run(6'd55, 32'h0, 1'b0, LIMIT - 1, 8'hFF, 8'h00, 32'h0);
    // R4: no status at all
    run(6'd41, 32'h4000_0000, 1'b0, 6000, 8'hFF, 8'h00, 32'h0);

    // R8: start while busy is ignored, inputs changes do not disturb frame
    launch(6'd24, 32'hA5A5_0F0F, 1'b0, 4, 8'hFF, 8'h00, 32'h0);
    repeat (8) @(negedge clk);
    cmd_index = 6'd33; cmd_arg = 32'h0; keep_sel = 1'b1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    judge(6'd24, 32'hA5A5_0F0F, 1'b0, 4, 8'h00, 32'h0);
    repeat (20) @(negedge clk);
    chk(log_tx.size() == total_for(6'd24, 1'b0, 4) && busy === 1'b0, "R8",
        "no command from ignored start", 64'(log_tx.size()), 64'(total_for(6'd24, 1'b0, 4)));

    // R9: start raised in the cmd_done cycle is accepted
    launch(6'd16, 32'h0000_0200, 1'b0, 0, 8'hFF, 8'h00, 32'h0);
    wait_done();
    judge(6'd16, 32'h0000_0200, 1'b0, 0, 8'h00, 32'h0);
    launch(6'd8, 32'h0000_01AA, 1'b0, 1, 8'hFF, 8'h05, 32'h0001_02AA);
    wait_done();
    judge(6'd8, 32'h0000_01AA, 1'b0, 1, 8'h05, 32'h0001_02AA);
    repeat (5) @(negedge clk);

    chk(proto_err == 0, "R9", "one request outstanding", 64'(proto_err), 64'd0);
    report();
  end

endmodule